// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one 32-bit single-precision word by another over several clock cycles. A one-cycle `start` pulse hands it a dividend and a divisor. The block raises `busy` and works out the sign of the result on its own. It takes the difference of the biased exponents and adds the bias back. It then divides the two 24-bit significands, each with its hidden one restored, using a restoring divider that produces one quotient bit per clock. When the last bit is in, it normalizes the quotient with at most one left shift, checks the exponent range and repacks the word. `done` then pulses for one cycle.

Operands with a special encoding never enter the iteration and are resolved in the cycle that accepts them: zero, infinity and NaN. Exponent code 0 counts as zero, so subnormal inputs are flushed. The significand quotient is truncated, with no rounding. Four status flags come with every result: invalid operation, divide by zero, overflow and underflow. Result and flags stay on the outputs until the next operation completes.

Top module: `fp_div`

## Requirements
- R1: For finite nonzero operands, bit 31 of the quotient is the XOR of the operand signs. Bits 30:23 hold dividend exponent minus divisor exponent plus 127. Bits 22:0 hold the fraction of the truncated significand quotient.
- R2: When the significand quotient is below 1, it is shifted left by one and the exponent is reduced by one. For example, 1.0/3.0 gives 0x3EAAAAAA.
- R3: If the final biased exponent is 255 or more, the result is infinity with the computed sign and the overflow flag is raised.
- R4: If the final biased exponent is 0 or less, the result is zero with the computed sign and the underflow flag is raised.
- R5: A finite nonzero dividend divided by zero gives infinity with the XOR sign and raises the divide-by-zero flag.
- R6: 0/0 and infinity/infinity give the quiet NaN 0x7FC00000 and raise the invalid flag. A NaN operand gives 0x7FC00000 with no flag.
- R7: Zero divided by a finite nonzero value, and a finite value divided by infinity, give zero with the XOR sign. Infinity divided by a finite value or by zero gives infinity with the XOR sign. No flag is raised in these cases.
- R8: Any operand with exponent code 0 is treated as zero of its sign, whatever its fraction.
- R9: The clock edge that accepts `start` counts as edge 1. `done` is high after edge 1 for special operands and after edge 27 for finite nonzero operands.
- R10: `done` is high for exactly one cycle. `busy` is high from the accepting edge through the `done` cycle and is low otherwise.
- R11: `start` is ignored while `busy` is high. The result in progress and its flags are not affected.
- R12: After reset, the quotient and all flags are 0 and `busy` and `done` are low.
- R13: Each result raises at most one of the four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the operands in this cycle (while not busy) |
| dividend | input | 32 | Dividend, single-precision |
| divisor | input | 32 | Divisor, single-precision |
| quotient | output | 32 | Result word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| div_zero | output | 1 | Divide-by-zero flag |
| ovf | output | 1 | Overflow flag |
| unf | output | 1 | Underflow flag |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. Because of this, every expected value is a real single-precision bit pattern that can be worked out by hand. The saturation points of the exponent are also easy to reach from ordinary operands: 254/1 versus 253, and the codes 255 and 0 after the bias is added back. These pairs place operands exactly on each side of the overflow and underflow boundaries. They also exercise the normalize decrement, which moves a result across the underflow line.

// File: rtl/fp_div.sv
module fp_div #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [EXP_W+FRAC_W:0]   dividend,
  input  logic [EXP_W+FRAC_W:0]   divisor,
  output logic [EXP_W+FRAC_W:0]   quotient,
  output logic                    busy,
  output logic                    done,
  output logic                    div_zero,
  output logic                    ovf,
  output logic                    unf,
  output logic                    invalid
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int MW   = FRAC_W + 1;
  localparam int QW   = FRAC_W + 2;
  localparam int XW   = EXP_W + 2;
  localparam int CW   = $clog2(QW);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic signed [XW-1:0] EMAX_S = XW'(EMAX);
  localparam logic signed [XW-1:0] ZERO_S = '0;
  localparam logic signed [XW-1:0] ONE_S  = XW'(1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PACK, S_FIN} state_t;
  state_t state;

  logic                 sgn;
  logic signed [XW-1:0] exr;
  logic [QW-1:0]        rem, q;
  logic [MW-1:0]        dvs;
  logic [CW-1:0]        cnt;
  logic [3:0]           flg;

  wire             sa = dividend[W-1];
  wire             sb = divisor[W-1];
  wire [EXP_W-1:0] ea = dividend[W-2:FRAC_W];
  wire [EXP_W-1:0] eb = divisor[W-2:FRAC_W];
  wire [FRAC_W-1:0] fa = dividend[FRAC_W-1:0];
  wire [FRAC_W-1:0] fb = divisor[FRAC_W-1:0];
  wire sq     = sa ^ sb;
  wire a_zero = (ea == '0);
  wire b_zero = (eb == '0);
  wire a_inf  = (&ea) && (fa == '0);
  wire b_inf  = (&eb) && (fb == '0);
  wire a_nan  = (&ea) && (fa != '0);
  wire b_nan  = (&eb) && (fb != '0);
  wire special = a_zero | b_zero | (&ea) | (&eb);

  logic [W-1:0] sp_q;
  logic [3:0]   sp_f;
  always_comb begin
    sp_q = {sq, {(W-1){1'b0}}};
    sp_f = 4'b0000;
    if (a_nan || b_nan) begin
      sp_q = QNAN;
    end else if ((a_zero && b_zero) || (a_inf && b_inf)) begin
      sp_q = QNAN;
      sp_f = 4'b1000;
    end else if (a_inf) begin
      sp_q = {sq, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (b_zero) begin
      sp_q = {sq, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      sp_f = 4'b0100;
    end
  end

  wire          ge   = rem >= {1'b0, dvs};
  wire [QW-1:0] diff = rem - {1'b0, dvs};

  wire                 hi    = q[QW-1];
  wire signed [XW-1:0] e_adj = hi ? exr : exr - ONE_S;
  wire [FRAC_W-1:0]    frac  = hi ? q[QW-2:1] : q[FRAC_W-1:0];

  logic [W-1:0] pk_q;
  logic [3:0]   pk_f;
  always_comb begin
    pk_q = {sgn, e_adj[EXP_W-1:0], frac};
    pk_f = 4'b0000;
    if (e_adj >= EMAX_S) begin
      pk_q = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      pk_f = 4'b0010;
    end else if (e_adj <= ZERO_S) begin
      pk_q = {sgn, {(W-1){1'b0}}};
      pk_f = 4'b0001;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sgn      <= 1'b0;
      exr      <= '0;
      rem      <= '0;
      q        <= '0;
      dvs      <= '0;
      cnt      <= '0;
      flg      <= '0;
      quotient <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (special) begin
            quotient <= sp_q;
            flg      <= sp_f;
            state    <= S_FIN;
          end else begin
            sgn   <= sq;
            exr   <= XW'({2'b00, ea}) - XW'({2'b00, eb}) + XW'(BIAS);
            rem   <= {2'b01, fa};
            dvs   <= {1'b1, fb};
            q     <= '0;
            cnt   <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          q   <= {q[QW-2:0], ge};
          rem <= ge ? (diff << 1) : (rem << 1);
          cnt <= cnt + 1'b1;
          if (cnt == CW'(QW - 1)) state <= S_PACK;
        end
        S_PACK: begin
          quotient <= pk_q;
          flg      <= pk_f;
          state    <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign invalid  = flg[3];
  assign div_zero = flg[2];
  assign ovf      = flg[1];
  assign unf      = flg[0];
endmodule

// File: rtl/fp_div_chk.sv
module fp_div_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [EXP_W+FRAC_W:0] quotient,
  input logic                  busy,
  input logic                  done,
  input logic                  div_zero,
  input logic                  ovf,
  input logic                  unf,
  input logic                  invalid
);
  localparam int W = EXP_W + FRAC_W + 1;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  busy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy);
  // R11
  quo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(quotient) |-> $rose(done));
  // R5
  dz_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quotient[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R6
  inv_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> ((&quotient[W-2:FRAC_W]) && quotient[FRAC_W-1]));
  // R3
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (quotient[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R4
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf) |-> (quotient[W-2:0] == '0));
  // R13
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({invalid, div_zero, ovf, unf}));
endmodule

bind fp_div fp_div_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .quotient(quotient),
  .busy(busy), .done(done), .div_zero(div_zero), .ovf(ovf),
  .unf(unf), .invalid(invalid)
);

// File: tb/tb_fp_div.sv
module tb_fp_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic [31:0] quotient;
  logic        busy, done, div_zero, ovf, unf, invalid;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp_div dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .busy(busy), .done(done), .div_zero(div_zero),
    .ovf(ovf), .unf(unf), .invalid(invalid)
  );

  // {dividend, divisor, quotient, flags{inv,dz,ovf,unf}, special}
  localparam int NV = 26;
  localparam logic [100:0] VEC [NV] = '{
    {32'h40C00000, 32'h40000000, 32'h40400000, 4'b0000, 1'b0},
    {32'h3F800000, 32'h40400000, 32'h3EAAAAAA, 4'b0000, 1'b0},
    {32'hC0F00000, 32'h40200000, 32'hC0400000, 4'b0000, 1'b0},
    {32'h3F800000, 32'hBF000000, 32'hC0000000, 4'b0000, 1'b0},
    {32'h3FC00000, 32'h3FE00000, 32'h3F5B6DB6, 4'b0000, 1'b0},
    {32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 4'b0000, 1'b0},
    {32'h3F800000, 32'h7E800000, 32'h00800000, 4'b0000, 1'b0},
    {32'h7F000000, 32'h00800000, 32'h7F800000, 4'b0010, 1'b0},
    {32'hFF000000, 32'h3F000000, 32'hFF800000, 4'b0010, 1'b0},
    {32'h00800000, 32'h7F000000, 32'h00000000, 4'b0001, 1'b0},
    {32'h3F800000, 32'h7EC00000, 32'h00000000, 4'b0001, 1'b0},
    {32'h80800000, 32'h7F000000, 32'h80000000, 4'b0001, 1'b0},
    {32'h3F800000, 32'h00000000, 32'h7F800000, 4'b0100, 1'b1},
    {32'hBF800000, 32'h00000000, 32'hFF800000, 4'b0100, 1'b1},
    {32'h3F800000, 32'h80000000, 32'hFF800000, 4'b0100, 1'b1},
    {32'h00000000, 32'h00000000, 32'h7FC00000, 4'b1000, 1'b1},
    {32'h7F800000, 32'hFF800000, 32'h7FC00000, 4'b1000, 1'b1},
    {32'h00000000, 32'h40A00000, 32'h00000000, 4'b0000, 1'b1},
    {32'h80000000, 32'h40A00000, 32'h80000000, 4'b0000, 1'b1},
    {32'h40400000, 32'hFF800000, 32'h80000000, 4'b0000, 1'b1},
    {32'hFF800000, 32'h40000000, 32'hFF800000, 4'b0000, 1'b1},
    {32'h7FC00000, 32'h3F800000, 32'h7FC00000, 4'b0000, 1'b1},
    {32'h3F800000, 32'h7F800001, 32'h7FC00000, 4'b0000, 1'b1},
    {32'h00400000, 32'h3F800000, 32'h00000000, 4'b0000, 1'b1},
    {32'h3F800000, 32'h00000001, 32'h7F800000, 4'b0100, 1'b1},
    {32'h7F800000, 32'h00000000, 32'h7F800000, 4'b0000, 1'b1}
  };

  function automatic string tag_of(int i);
    if (i == 1 || i == 4) return "R2";
    if (i <= 6)  return "R1";
    if (i <= 8)  return "R3";
    if (i <= 11) return "R4";
    if (i <= 14) return "R5";
    if (i == 15 || i == 16 || i == 21 || i == 22) return "R6";
    if (i == 23 || i == 24) return "R8";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
    end
  endtask

  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(posedge clk); #1;
    start    = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk(quotient == 32'h0, "R12", "quotient after reset", quotient, 32'h0);
    chk({busy, done, invalid, div_zero, ovf, unf} == 6'b0, "R12", "busy/done/flags after reset",
        {26'h0, busy, done, invalid, div_zero, ovf, unf}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] a, b, eq;
      logic [3:0]  ef;
      logic        sp;
      {a, b, eq, ef, sp} = VEC[i];
      launch(a, b);
      wait_done(n);
      chk(quotient == eq, tag_of(i), $sformatf("quotient vec %0d", i), quotient, eq);
      chk({invalid, div_zero, ovf, unf} == ef, tag_of(i), $sformatf("flags vec %0d", i),
          {28'h0, invalid, div_zero, ovf, unf}, {28'h0, ef});
      // R9 latency
      chk(n == (sp ? 0 : 26), "R9", $sformatf("latency vec %0d", i), n, sp ? 0 : 26);
      @(posedge clk); #1;
      // R10 single-cycle done, busy drops
      chk(!done && !busy, "R10", $sformatf("done/busy after vec %0d", i),
          {30'h0, done, busy}, 32'h0);
    end

    // R10 busy high during iteration; R11 start ignored while busy
    launch(32'h40C00000, 32'h40000000);
    chk(busy && !done, "R10", "busy while iterating", {30'h0, busy, done}, 32'h2);
    repeat (3) @(posedge clk);
    #1;
    dividend = 32'h3F800000;
    divisor  = 32'h00000000;
    start    = 1'b1;
    @(posedge clk); #1;
    start    = 1'b0;
    wait_done(n);
    chk(n == 22, "R11", "latency unchanged by start while busy", n, 22);
    chk(quotient == 32'h40400000, "R11", "result unaffected by start while busy", quotient, 32'h40400000);
    chk({invalid, div_zero, ovf, unf} == 4'b0, "R11", "flags unaffected by start while busy",
        {28'h0, invalid, div_zero, ovf, unf}, 32'h0);
    // start held high in the done cycle must also be ignored
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(!busy && !done, "R11", "start during done cycle ignored", {30'h0, busy, done}, 32'h0);
    chk(quotient == 32'h40400000, "R11", "quotient held after ignored start", quotient, 32'h40400000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule